// File: doc/BRIEF.md
# Two-Bank Interleaved 2bpp Framebuffer Scanout

This block turns a packed framebuffer into a raster of 2-bit colour indices. The picture is 320 pixels wide and 200 lines tall. Every byte holds four pixels. Video memory is split into two 8 KB banks. Lines 0, 2, 4 and so on come from bank 0, and lines 1, 3, 5 and so on come from bank 1. Each bank has its own running byte pointer. That pointer only moves on lines of that bank's parity, so the block never multiplies a row number by a pitch.

The block does not generate raster timing. An outside timing unit supplies three inputs:
- a pixel clock enable,
- a start-of-frame pulse,
- a start-of-line pulse, given one pixel slot before the first visible pixel.

Both banks sit outside the block. Each bank is a synchronous single-port RAM with one cycle of read latency. The block drives each bank's enable, write enable, address and write data, and takes back its read data. A CPU write channel shares the bank ports. A write is steered by address bit 13, and it is held off whenever scanout is reading the same bank in that clock.

The pixel output has a valid flag and no ready input. The raster owns the pace, so the pixel stream cannot be back-pressured. The CPU write channel is valid/ready. A write completes in a clock where both `cpu_wr_valid` and `cpu_wr_ready` are high. While `cpu_wr_ready` is low, the writer must hold its address and data steady. `cpu_wr_ready` is a function of the current scanout read and of the requested address only. It never depends on `cpu_wr_valid`.

Top module: `fb2bpp_scanout`

## Requirements
- R1: After reset, `pix_valid` is 0, `pix_idx` is 0, no bank is enabled, and `cpu_wr_ready` is 1.
- R2: A byte is shown as four pixels, left to right: bits 7:6, then 5:4, then 3:2, then 1:0.
- R3: Scanout reads for an even line (counted from 0 after the frame pulse) go only to bank 0 (`bank_en[0]`). Reads for an odd line go only to bank 1.
- R4: Each bank pointer starts a frame at 0. It advances by one per byte fetched and carries on across the lines of its parity, so line L starts at address (L>>1)*80 in its bank. Line 199 ends at 7999.
- R5: `frame_start` clears both pointers and the line count, and stops any line in progress.
- R6: A `line_start` accepted on a pixel slot is followed, on the next 320 pixel slots, by 320 valid pixels with no gaps. On the slot after those, `pix_valid` is 0.
- R7: After 200 lines in a frame, further `line_start` pulses cause no bank reads and no valid pixels. Whenever `pix_valid` is 0, `pix_idx` is 0.
- R8: The first byte of a line is read in the `line_start` slot. Each later byte is read in the slot that outputs the fourth pixel of the previous byte. That gives exactly 80 reads per line.
- R9: A CPU write enables bank `cpu_wr_addr[13]` with write enable set. It drives that bank's address with `cpu_wr_addr[12:0]` and drives `bank_wdata` with `cpu_wr_data`.
- R10: When a scanout read and a CPU write target the same bank in one clock, the read takes the port and `cpu_wr_ready` is 0. A write to the other bank in that clock proceeds.
- R11: Bank read data is taken on the clock after the read. It is kept inside the block, so the timing is correct however many clocks pass before the next pixel slot.
- R12: In clocks where `pix_ce` is 0, `pix_valid` and `pix_idx` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pix_ce | input | 1 | Pixel slot enable |
| frame_start | input | 1 | Start-of-frame pulse; clears pointers and line count |
| line_start | input | 1 | Start-of-line pulse, sampled on a pixel slot |
| pix_valid | output | 1 | Pixel index is inside the visible window |
| pix_idx | output | 2 | Pixel colour index |
| cpu_wr_valid | input | 1 | CPU write request |
| cpu_wr_ready | output | 1 | CPU write accepted this clock if valid |
| cpu_wr_addr | input | 14 | Bit 13 selects the bank, bits 12:0 are the byte address |
| cpu_wr_data | input | 8 | CPU write byte |
| bank_en | output | 2 | Per-bank port enable |
| bank_we | output | 2 | Per-bank write enable |
| bank_addr | output | 2x13 | Per-bank byte address |
| bank_wdata | output | 8 | Write data shared by both banks |
| bank_rdata | input | 2x8 | Per-bank read data, one clock after the read |

## Verification
The bench targets three kinds of corner case.

The first is the byte boundary when pixel slots come every clock. If the design fetched too late, it would show stale or garbage data on the first pixel of each new byte. The RAM model drives junk on every clock without a read, which exposes this. The same lines are then run with a dead clock between slots. A design that relied on the read data still being on the RAM port would pick up that junk.

The second is where the pointers sit at line and frame edges. The bench checks the first address of each line and the bank each line reads from. A single shared pointer, a row that restarted at zero, or a pointer that survived a new frame would each show up as a wrong address.

The third is the edges of the visible window and the shared port. Lines beyond 200 must stay dark and read nothing. A CPU write that collides with a scanout read must lose to the read and see `cpu_wr_ready` low, while a write to the other bank goes through.

// File: rtl/fbs_pkg.sv
package fbs_pkg;
  localparam int NBANK  = 2;
  localparam int BYTE_W = 8;
endpackage

// File: rtl/fbs_line_ctrl.sv
module fbs_line_ctrl #(
  parameter int H_PIX   = 320,
  parameter int V_LINES = 200,
  parameter int BPP     = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         pix_ce,
  input  logic                         frame_start,
  input  logic                         line_start,
  output logic                         emit,
  output logic                         first_of_byte,
  output logic                         rd_req,
  output logic                         rd_bank
);
  localparam int PPB = fbs_pkg::BYTE_W / BPP;
  localparam int SW  = $clog2(PPB);
  localparam int CW  = $clog2(H_PIX);
  localparam int LW  = $clog2(V_LINES + 1);

  logic [LW-1:0] line_q;
  logic [CW-1:0] col_q;
  logic          run_q;
  logic          par_q;
  logic          start_fire;
  logic          last_sub;

  assign start_fire    = pix_ce && line_start && !frame_start && (line_q < LW'(V_LINES));
  assign emit          = pix_ce && run_q && !frame_start && !start_fire;
  assign first_of_byte = (col_q[SW-1:0] == '0);
  assign last_sub      = (col_q[SW-1:0] == '1);

  // first byte at line start, next byte while the last pixel of a byte is shown
  assign rd_req  = start_fire || (emit && last_sub && (col_q != CW'(H_PIX - 1)));
  assign rd_bank = start_fire ? line_q[0] : par_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      line_q <= '0;
      col_q  <= '0;
      run_q  <= 1'b0;
      par_q  <= 1'b0;
    end else if (frame_start) begin
      line_q <= '0;
      col_q  <= '0;
      run_q  <= 1'b0;
    end else if (start_fire) begin
      run_q  <= 1'b1;
      col_q  <= '0;
      par_q  <= line_q[0];
      line_q <= line_q + 1'b1;
    end else if (emit) begin
      col_q <= col_q + 1'b1;
      if (col_q == CW'(H_PIX - 1)) run_q <= 1'b0;
    end
  end
endmodule

// File: rtl/fbs_addr_gen.sv
module fbs_addr_gen #(
  parameter int AW = 13
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                frame_start,
  input  logic                                rd_req,
  input  logic                                rd_bank,
  output logic [fbs_pkg::NBANK-1:0][AW-1:0]   rd_ptr
);
  for (genvar b = 0; b < fbs_pkg::NBANK; b++) begin : g_ptr
    logic [AW-1:0] ptr_q;
    always_ff @(posedge clk) begin
      if (!rst_n || frame_start) ptr_q <= '0;
      else if (rd_req && (rd_bank == 1'(b))) ptr_q <= ptr_q + 1'b1;
    end
    assign rd_ptr[b] = ptr_q;
  end
endmodule

// File: rtl/fbs_bank_arb.sv
module fbs_bank_arb #(
  parameter int AW = 13
) (
  input  logic                                        rd_req,
  input  logic                                        rd_bank,
  input  logic [fbs_pkg::NBANK-1:0][AW-1:0]           rd_ptr,
  input  logic                                        cpu_valid,
  input  logic [AW:0]                                 cpu_addr,
  input  logic [fbs_pkg::BYTE_W-1:0]                  cpu_data,
  output logic                                        cpu_ready,
  output logic [fbs_pkg::NBANK-1:0]                   bank_en,
  output logic [fbs_pkg::NBANK-1:0]                   bank_we,
  output logic [fbs_pkg::NBANK-1:0][AW-1:0]           bank_addr,
  output logic [fbs_pkg::BYTE_W-1:0]                  bank_wdata
);
  assign cpu_ready  = !(rd_req && (rd_bank == cpu_addr[AW]));
  assign bank_wdata = cpu_data;

  for (genvar b = 0; b < fbs_pkg::NBANK; b++) begin : g_port
    logic rd_hit, wr_hit;
    assign rd_hit       = rd_req && (rd_bank == 1'(b));
    assign wr_hit       = cpu_valid && (cpu_addr[AW] == 1'(b));
    assign bank_en[b]   = rd_hit || wr_hit;
    assign bank_we[b]   = wr_hit && !rd_hit;
    assign bank_addr[b] = rd_hit ? rd_ptr[b] : cpu_addr[AW-1:0];
  end
endmodule

// File: rtl/fbs_pixel_shift.sv
module fbs_pixel_shift #(
  parameter int BPP = 2
) (
  input  logic                                              clk,
  input  logic                                              rst_n,
  input  logic                                              pix_ce,
  input  logic                                              frame_start,
  input  logic                                              emit,
  input  logic                                              first_of_byte,
  input  logic                                              rd_req,
  input  logic                                              rd_bank,
  input  logic [fbs_pkg::NBANK-1:0][fbs_pkg::BYTE_W-1:0]    bank_rdata,
  output logic                                              pix_valid,
  output logic [BPP-1:0]                                    pix_idx
);
  localparam int BW = fbs_pkg::BYTE_W;

  logic          rdv_q;
  logic          rdb_q;
  logic [BW-1:0] hold_q;
  logic [BW-1:0] shift_q;
  logic [BW-1:0] byte_now;

  // fresh RAM data bypasses the holding register when the slot follows at once
  assign byte_now = rdv_q ? bank_rdata[rdb_q] : hold_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdv_q     <= 1'b0;
      rdb_q     <= 1'b0;
      hold_q    <= '0;
      shift_q   <= '0;
      pix_valid <= 1'b0;
      pix_idx   <= '0;
    end else begin
      rdv_q <= rd_req;
      rdb_q <= rd_bank;
      if (rdv_q) hold_q <= bank_rdata[rdb_q];
      if (frame_start) begin
        pix_valid <= 1'b0;
        pix_idx   <= '0;
      end else if (pix_ce) begin
        if (emit) begin
          pix_valid <= 1'b1;
          if (first_of_byte) begin
            pix_idx <= byte_now[BW-1 -: BPP];
            shift_q <= byte_now << BPP;
          end else begin
            pix_idx <= shift_q[BW-1 -: BPP];
            shift_q <= shift_q << BPP;
          end
        end else begin
          pix_valid <= 1'b0;
          pix_idx   <= '0;
        end
      end
    end
  end
endmodule

// File: rtl/fb2bpp_scanout.sv
module fb2bpp_scanout #(
  parameter int H_PIX   = 320,
  parameter int V_LINES = 200,
  parameter int BPP     = 2,
  parameter int BANK_AW = 13
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          pix_ce,
  input  logic                          frame_start,
  input  logic                          line_start,
  output logic                          pix_valid,
  output logic [BPP-1:0]                pix_idx,
  input  logic                          cpu_wr_valid,
  output logic                          cpu_wr_ready,
  input  logic [BANK_AW:0]              cpu_wr_addr,
  input  logic [7:0]                    cpu_wr_data,
  output logic [1:0]                    bank_en,
  output logic [1:0]                    bank_we,
  output logic [1:0][BANK_AW-1:0]       bank_addr,
  output logic [7:0]                    bank_wdata,
  input  logic [1:0][7:0]               bank_rdata
);
  logic                                   emit;
  logic                                   first_of_byte;
  logic                                   rd_req;
  logic                                   rd_bank;
  logic [fbs_pkg::NBANK-1:0][BANK_AW-1:0] rd_ptr;

  fbs_line_ctrl #(.H_PIX(H_PIX), .V_LINES(V_LINES), .BPP(BPP)) u_line (
    .clk(clk), .rst_n(rst_n), .pix_ce(pix_ce), .frame_start(frame_start),
    .line_start(line_start), .emit(emit), .first_of_byte(first_of_byte),
    .rd_req(rd_req), .rd_bank(rd_bank)
  );

  fbs_addr_gen #(.AW(BANK_AW)) u_addr (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
    .rd_req(rd_req), .rd_bank(rd_bank), .rd_ptr(rd_ptr)
  );

  fbs_bank_arb #(.AW(BANK_AW)) u_arb (
    .rd_req(rd_req), .rd_bank(rd_bank), .rd_ptr(rd_ptr),
    .cpu_valid(cpu_wr_valid), .cpu_addr(cpu_wr_addr), .cpu_data(cpu_wr_data),
    .cpu_ready(cpu_wr_ready), .bank_en(bank_en), .bank_we(bank_we),
    .bank_addr(bank_addr), .bank_wdata(bank_wdata)
  );

  fbs_pixel_shift #(.BPP(BPP)) u_pix (
    .clk(clk), .rst_n(rst_n), .pix_ce(pix_ce), .frame_start(frame_start),
    .emit(emit), .first_of_byte(first_of_byte), .rd_req(rd_req),
    .rd_bank(rd_bank), .bank_rdata(bank_rdata),
    .pix_valid(pix_valid), .pix_idx(pix_idx)
  );
endmodule

// File: rtl/fbs_scanout_chk.sv
module fbs_scanout_chk #(
  parameter int H_PIX   = 320,
  parameter int BPP     = 2,
  parameter int BANK_AW = 13
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    pix_ce,
  input logic                    frame_start,
  input logic                    pix_valid,
  input logic [BPP-1:0]          pix_idx,
  input logic                    cpu_wr_valid,
  input logic                    cpu_wr_ready,
  input logic [BANK_AW:0]        cpu_wr_addr,
  input logic [1:0]              bank_en,
  input logic [1:0]              bank_we,
  input logic [1:0][BANK_AW-1:0] bank_addr
);
  logic        ce_q;
  logic [15:0] run_cnt;
  logic        tb;

  assign tb = cpu_wr_addr[BANK_AW];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ce_q    <= 1'b0;
      run_cnt <= '0;
    end else begin
      ce_q <= pix_ce;
      if (!pix_valid) run_cnt <= '0;
      else if (ce_q)  run_cnt <= run_cnt + 1'b1;
    end
  end

  AST_DARK_IDX: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_valid |-> (pix_idx == '0)); // R7
  AST_SINGLE_READER: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(bank_en & ~bank_we) <= 1); // R3
  AST_CPU_YIELDS: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr_valid && !cpu_wr_ready) |-> (bank_en[tb] && !bank_we[tb])); // R10
  AST_CPU_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr_valid && cpu_wr_ready) |-> (bank_en[tb] && bank_we[tb] &&
      bank_addr[tb] == cpu_wr_addr[BANK_AW-1:0])); // R9
  AST_HOLD_OFF_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    (!pix_ce && !frame_start) |=> ($stable(pix_valid) && $stable(pix_idx))); // R12
  AST_LINE_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    run_cnt <= 16'(H_PIX)); // R6
endmodule

bind fb2bpp_scanout fbs_scanout_chk #(.H_PIX(H_PIX), .BPP(BPP), .BANK_AW(BANK_AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .pix_ce(pix_ce), .frame_start(frame_start),
  .pix_valid(pix_valid), .pix_idx(pix_idx), .cpu_wr_valid(cpu_wr_valid),
  .cpu_wr_ready(cpu_wr_ready), .cpu_wr_addr(cpu_wr_addr), .bank_en(bank_en),
  .bank_we(bank_we), .bank_addr(bank_addr)
);

// File: tb/fb2bpp_scanout_test.sv
`timescale 1ns/1ps
module fb2bpp_scanout_test;
  localparam int H_PIX = 320;
  localparam int BPL   = 80;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             pix_ce = 1'b0, frame_start = 1'b0, line_start = 1'b0;
  logic             pix_valid;
  logic [1:0]       pix_idx;
  logic             cpu_wr_valid = 1'b0;
  logic             cpu_wr_ready;
  logic [13:0]      cpu_wr_addr = '0;
  logic [7:0]       cpu_wr_data = '0;
  logic [1:0]       bank_en, bank_we;
  logic [1:0][12:0] bank_addr;
  logic [7:0]       bank_wdata;
  logic [1:0][7:0]  bank_rdata;

  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;

  fb2bpp_scanout uut (
    .clk(clk), .rst_n(rst_n), .pix_ce(pix_ce), .frame_start(frame_start),
    .line_start(line_start), .pix_valid(pix_valid), .pix_idx(pix_idx),
    .cpu_wr_valid(cpu_wr_valid), .cpu_wr_ready(cpu_wr_ready),
    .cpu_wr_addr(cpu_wr_addr), .cpu_wr_data(cpu_wr_data),
    .bank_en(bank_en), .bank_we(bank_we), .bank_addr(bank_addr),
    .bank_wdata(bank_wdata), .bank_rdata(bank_rdata)
  );

  function automatic logic [7:0] mem_f(input int b, input int a);
    return 8'((a * 7) ^ (a >> 5) ^ (b * 90) ^ 8'h35);
  endfunction

  // RAM model: data one clock after a read, junk otherwise
  always_ff @(posedge clk) begin
    for (int b = 0; b < 2; b++) begin
      if (bank_en[b] && !bank_we[b]) bank_rdata[b] <= mem_f(b, int'(bank_addr[b]));
      else bank_rdata[b] <= 8'hC3 ^ 8'(b);
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pulse_frame();
    @(negedge clk);
    frame_start = 1'b1; pix_ce = 1'b0; line_start = 1'b0;
    @(posedge clk); @(negedge clk);
    frame_start = 1'b0;
  endtask

  // one line: slot 0 carries line_start, then 320 pixel slots, then 2 idle slots
  task automatic run_line(input int L, input int gap, input bit act);
    int nval = 0, nbad = 0, nrd = 0, nwrong = 0, first = -1, abad = 0, hbad = 0;
    int bad_act = 0, bad_exp = 0;
    int eb = L & 1;
    int base = (L >> 1) * BPL;
    for (int s = 0; s < H_PIX + 3; s++) begin
      if (gap != 0 && s > 0) begin
        logic       pv;
        logic [1:0] pi;
        pv = pix_valid; pi = pix_idx;
        pix_ce = 1'b0;
        @(posedge clk); @(negedge clk);
        if (pix_valid !== pv || pix_idx !== pi) hbad++;
      end
      pix_ce = 1'b1; line_start = (s == 0);
      #1;
      for (int b = 0; b < 2; b++) begin
        if (bank_en[b] && !bank_we[b]) begin
          if (b != eb) nwrong++;
          else begin
            if (nrd == 0) first = int'(bank_addr[b]);
            else if (int'(bank_addr[b]) != base + nrd) abad++;
            if (!(s == 0 || (s % 4 == 0 && s <= H_PIX - 4))) abad++;
            nrd++;
          end
        end
      end
      @(posedge clk); @(negedge clk);
      line_start = 1'b0;
      if (pix_valid) nval++;
      begin
        bit         ev;
        logic [1:0] ei;
        ev = act && s >= 1 && s <= H_PIX;
        ei = ev ? 2'((mem_f(eb, base + (s - 1) / 4) >> (6 - 2 * ((s - 1) % 4))) & 8'h3) : 2'd0;
        if (pix_valid !== ev || pix_idx !== ei) begin
          if (nbad == 0) begin bad_act = int'(pix_idx); bad_exp = int'(ei); end
          nbad++;
        end
      end
    end
    pix_ce = 1'b0;
    chk(nval == (act ? H_PIX : 0), act ? "R6 valid pixel count" : "R7 valid outside window", nval, act ? H_PIX : 0);
    chk(nbad == 0, act ? "R2 pixel values and order" : "R7 dark idx", bad_act, bad_exp);
    chk(nrd == (act ? BPL : 0), act ? "R8 reads per line" : "R7 reads outside window", nrd, act ? BPL : 0);
    chk(nwrong == 0, "R3 bank parity", nwrong, 0);
    if (act) chk(first == base, "R4 line start address", first, base);
    chk(abad == 0, "R8 read slot and address sequence", abad, 0);
    if (gap != 0) chk(hbad == 0, "R12 hold between slots", hbad, 0);
  endtask

  task automatic test_reset();
    @(negedge clk);
    chk(pix_valid == 1'b0, "R1 valid after reset", int'(pix_valid), 0);
    chk(pix_idx == 2'd0, "R1 idx after reset", int'(pix_idx), 0);
    chk(bank_en == 2'b00, "R1 bank idle after reset", int'(bank_en), 0);
    chk(cpu_wr_ready == 1'b1, "R1 cpu ready after reset", int'(cpu_wr_ready), 1);
  endtask

  task automatic test_back_to_back();
    pulse_frame();
    for (int L = 0; L < 4; L++) run_line(L, 0, 1'b1);
  endtask

  task automatic test_gapped();
    // R11 and R12: a dead clock between slots, RAM drives junk there
    run_line(4, 1, 1'b1);
    run_line(5, 1, 1'b1);
  endtask

  task automatic test_restart();
    // R5: new frame mid-way restarts pointers and parity
    pulse_frame();
    run_line(0, 0, 1'b1);
    run_line(1, 0, 1'b1);
  endtask

  task automatic test_full_frame();
    pulse_frame();
    for (int L = 0; L < 200; L++) run_line(L, 0, 1'b1);
    run_line(200, 0, 1'b0);  // R7
    run_line(201, 0, 1'b0);  // R7
  endtask

  task automatic test_cpu_write();
    pulse_frame();
    @(negedge clk);
    cpu_wr_valid = 1'b1; cpu_wr_addr = 14'h2005; cpu_wr_data = 8'hA7;
    #1;
    chk(cpu_wr_ready == 1'b1, "R9 ready when idle", int'(cpu_wr_ready), 1);
    chk(bank_en == 2'b10 && bank_we == 2'b10, "R9 bank1 selected by bit 13", int'({bank_en, bank_we}), 'hA);
    chk(bank_addr[1] == 13'h0005 && bank_wdata == 8'hA7, "R9 bank1 address and data",
        int'({bank_addr[1], bank_wdata}), int'({13'h0005, 8'hA7}));
    cpu_wr_addr = 14'h0123; cpu_wr_data = 8'h3C;
    #1;
    chk(bank_en == 2'b01 && bank_we == 2'b01 && bank_addr[0] == 13'h0123,
        "R9 bank0 selected", int'(bank_addr[0]), 'h123);
    @(posedge clk); @(negedge clk);
    cpu_wr_valid = 1'b0;
  endtask

  task automatic test_conflict();
    pulse_frame();
    @(negedge clk);
    pix_ce = 1'b1; line_start = 1'b1;
    cpu_wr_valid = 1'b1; cpu_wr_addr = 14'h0055; cpu_wr_data = 8'h11;
    #1;
    chk(cpu_wr_ready == 1'b0, "R10 ready low on same bank", int'(cpu_wr_ready), 0);
    chk(bank_en[0] && !bank_we[0] && bank_addr[0] == 13'd0, "R10 read owns bank0",
        int'(bank_addr[0]), 0);
    cpu_wr_addr = 14'h2044;
    #1;
    chk(cpu_wr_ready == 1'b1, "R10 other bank ready", int'(cpu_wr_ready), 1);
    chk(bank_we[1] && bank_addr[1] == 13'h0044 && bank_en[0] && !bank_we[0],
        "R10 other bank write proceeds", int'(bank_addr[1]), 'h44);
    @(posedge clk); @(negedge clk);
    cpu_wr_valid = 1'b0; line_start = 1'b0; pix_ce = 1'b0;
    pulse_frame();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL R6 watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    test_reset();
    test_back_to_back();
    test_gapped();
    test_restart();
    test_cpu_write();
    test_conflict();
    test_full_frame();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule